// File: doc/BRIEF.md
# Operand Precision Scheduler with Rate Enable

This block takes two multiplier operands one after the other on one shared 32-bit word input. A word strobe marks each valid word, and a select line says which operand it is: a low select loads the first operand and a high select loads the second. Loading the second operand starts a classification. On the next clock the block measures both held operands and sorts the pair into one of three precision classes. It sends the pair to the output pair of that class width and publishes a 2-bit precision code.

That precision code drives a clock-enable generator. The generator paces the downstream multiplier at a quarter, half or full clock rate, depending on the class. The enable is an ordinary single-cycle enable in the main clock domain, not a divided clock. When the code changes, the pacing counter restarts so that the new rate begins cleanly.

Top module: `prec_sched_top`

## Requirements
- R1: A word is loaded only in a cycle with `word_vld_i` high: `op_sel_i`=0 loads the first operand, `op_sel_i`=1 loads the second; words with `word_vld_i` low change nothing at the outputs.
- R2: One clock after a second operand is loaded, `pair_vld_o` is high for exactly one cycle, and the precision code and pair outputs take their new values in that same cycle and hold them until the next pair.
- R3: If both operands are below 256, `prec_o` is 1 (binary 01) and `a8_o`/`b8_o` carry bits [7:0] of the first and second operand.
- R4: Otherwise, if both operands are below 32768, `prec_o` is 2 (binary 10) and `a16_o`/`b16_o` carry bits [15:0] of the operands.
- R5: In every other case `prec_o` is 3 (binary 11) and `a32_o`/`b32_o` carry the full operands.
- R6: The output pairs of the two classes not chosen are driven to zero.
- R7: With precision code 1, `clk_en_o` is high in one cycle of every 4.
- R8: With precision code 2, `clk_en_o` is high in one cycle of every 2.
- R9: With precision code 3, `clk_en_o` is high in every cycle.
- R10: With precision code 0 (idle), `clk_en_o` stays low.
- R11: When the precision code changes, the pacing counter restarts: counting the first cycle that shows the new code as cycle 0, the first enable comes in cycle P (P = 4, 2 or 1) and none comes earlier.
- R12: Reset (active-low, asynchronous) clears both operand registers, sets the precision code to 0 and all pair outputs, `pair_vld_o` and `clk_en_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 32 | Shared operand word |
| word_vld_i | input | 1 | Word strobe |
| op_sel_i | input | 1 | 0 = first operand, 1 = second operand |
| pair_vld_o | output | 1 | One-cycle pulse when a classified pair appears |
| prec_o | output | 2 | Precision code: 0 idle, 1 narrow, 2 mid, 3 wide |
| a8_o | output | 8 | First operand, narrow class |
| b8_o | output | 8 | Second operand, narrow class |
| a16_o | output | 16 | First operand, mid class |
| b16_o | output | 16 | Second operand, mid class |
| a32_o | output | 32 | First operand, wide class |
| b32_o | output | 32 | Second operand, wide class |
| clk_en_o | output | 1 | Rate enable for the downstream multiplier |

## Verification
Two events can fall in the same clock edge. A fresh first operand can be loaded in the cycle where the previous pair is being classified, and the classification must still use the operand that was held before. To provoke this, the bench drives a new first word immediately after the second. It then checks that the published pair still shows the old first operand and that the next pair uses the new one. The bench also watches the edge where the code changes, where a counter wrap and a restart meet. It records the enable cycle by cycle from the first cycle of each new code and compares the record against the restart pattern.

// File: rtl/prec_sched_pkg.sv
package prec_sched_pkg;
  typedef enum logic [1:0] {
    PREC_IDLE = 2'd0,
    PREC_NARROW = 2'd1,
    PREC_MID = 2'd2,
    PREC_WIDE = 2'd3
  } prec_e;
endpackage

// File: rtl/prec_operand_capture.sv
module prec_operand_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              op_sel_i,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o,
  output logic              pair_rdy_o
);
  logic load_a, load_b;
  assign load_a = word_vld_i & ~op_sel_i;
  assign load_b = word_vld_i & op_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_o     <= '0;
      op_b_o     <= '0;
      pair_rdy_o <= 1'b0;
    end else begin
      if (load_a) op_a_o <= word_i;
      if (load_b) op_b_o <= word_i;
      pair_rdy_o <= load_b;
    end
  end

  // R1
  pair_rdy_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_rdy_o |-> $past(word_vld_i && op_sel_i));
  // R1
  op_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_vld_i && !op_sel_i) |=> $stable(op_a_o));
endmodule

// File: rtl/prec_classifier.sv
module prec_classifier
  import prec_sched_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16,
  parameter int MID_LIM  = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   op_a_i,
  input  logic [DATA_W-1:0]   op_b_i,
  input  logic                pair_rdy_i,
  output logic                pair_vld_o,
  output prec_e               prec_o,
  output logic [NARROW_W-1:0] a_nar_o,
  output logic [NARROW_W-1:0] b_nar_o,
  output logic [MID_W-1:0]    a_mid_o,
  output logic [MID_W-1:0]    b_mid_o,
  output logic [DATA_W-1:0]   a_wide_o,
  output logic [DATA_W-1:0]   b_wide_o
);
  logic  fits_nar, fits_mid;
  prec_e cls;

  // upper bits zero means the value is below 2**bits
  assign fits_nar = ~|op_a_i[DATA_W-1:NARROW_W] & ~|op_b_i[DATA_W-1:NARROW_W];
  assign fits_mid = ~|op_a_i[DATA_W-1:MID_LIM]  & ~|op_b_i[DATA_W-1:MID_LIM];

  always_comb begin
    if (fits_nar)      cls = PREC_NARROW;
    else if (fits_mid) cls = PREC_MID;
    else               cls = PREC_WIDE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_vld_o <= 1'b0;
      prec_o     <= PREC_IDLE;
      a_nar_o    <= '0;
      b_nar_o    <= '0;
      a_mid_o    <= '0;
      b_mid_o    <= '0;
      a_wide_o   <= '0;
      b_wide_o   <= '0;
    end else begin
      pair_vld_o <= pair_rdy_i;
      if (pair_rdy_i) begin
        prec_o   <= cls;
        a_nar_o  <= (cls == PREC_NARROW) ? op_a_i[NARROW_W-1:0] : '0;
        b_nar_o  <= (cls == PREC_NARROW) ? op_b_i[NARROW_W-1:0] : '0;
        a_mid_o  <= (cls == PREC_MID)    ? op_a_i[MID_W-1:0]    : '0;
        b_mid_o  <= (cls == PREC_MID)    ? op_b_i[MID_W-1:0]    : '0;
        a_wide_o <= (cls == PREC_WIDE)   ? op_a_i               : '0;
        b_wide_o <= (cls == PREC_WIDE)   ? op_b_i               : '0;
      end
    end
  end

  // R2
  pair_vld_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |-> $past(pair_rdy_i));
  // R2
  prec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_vld_o |-> $stable(prec_o));
  // R6
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prec_o == PREC_NARROW) |-> (a_mid_o == '0 && b_mid_o == '0 && a_wide_o == '0 && b_wide_o == '0));
endmodule

// File: rtl/prec_rate_gen.sv
module prec_rate_gen
  import prec_sched_pkg::*;
#(
  parameter int SLOW_DIV = 4,
  parameter int MID_DIV  = 2,
  localparam int CNT_W   = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  prec_e rate_i,
  output logic  clk_en_o
);
  prec_e            rate_q;
  logic [CNT_W-1:0] cnt_q, last;
  logic             changed;

  always_comb begin
    case (rate_i)
      PREC_NARROW: last = CNT_W'(SLOW_DIV - 1);
      PREC_MID:    last = CNT_W'(MID_DIV - 1);
      default:     last = '0;
    endcase
  end

  assign changed  = (rate_i != rate_q);
  assign clk_en_o = !changed && (rate_i != PREC_IDLE) && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= PREC_IDLE;
      cnt_q  <= '0;
    end else begin
      rate_q <= rate_i;
      if (changed || rate_i == PREC_IDLE || cnt_q == last) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> (rate_i != PREC_IDLE));
  // R9
  full_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == PREC_WIDE && rate_q == PREC_WIDE) |-> clk_en_o);
  // R8
  half_rate_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && rate_i == PREC_MID) |=> !clk_en_o);
  // R11
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed |-> !clk_en_o);
endmodule

// File: rtl/prec_sched_top.sv
module prec_sched_top
  import prec_sched_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16,
  parameter int MID_LIM  = 15,
  parameter int SLOW_DIV = 4,
  parameter int MID_DIV  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   word_i,
  input  logic                word_vld_i,
  input  logic                op_sel_i,
  output logic                pair_vld_o,
  output logic [1:0]          prec_o,
  output logic [NARROW_W-1:0] a8_o,
  output logic [NARROW_W-1:0] b8_o,
  output logic [MID_W-1:0]    a16_o,
  output logic [MID_W-1:0]    b16_o,
  output logic [DATA_W-1:0]   a32_o,
  output logic [DATA_W-1:0]   b32_o,
  output logic                clk_en_o
);
  logic [DATA_W-1:0] op_a, op_b;
  logic              pair_rdy;
  prec_e             prec;

  prec_operand_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i, .rst_ni, .word_i, .word_vld_i, .op_sel_i,
    .op_a_o(op_a), .op_b_o(op_b), .pair_rdy_o(pair_rdy)
  );

  prec_classifier #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .MID_W(MID_W), .MID_LIM(MID_LIM)
  ) u_classify (
    .clk_i, .rst_ni, .op_a_i(op_a), .op_b_i(op_b), .pair_rdy_i(pair_rdy),
    .pair_vld_o, .prec_o(prec),
    .a_nar_o(a8_o), .b_nar_o(b8_o), .a_mid_o(a16_o), .b_mid_o(b16_o),
    .a_wide_o(a32_o), .b_wide_o(b32_o)
  );

  prec_rate_gen #(.SLOW_DIV(SLOW_DIV), .MID_DIV(MID_DIV)) u_rate (
    .clk_i, .rst_ni, .rate_i(prec), .clk_en_o
  );

  assign prec_o = prec;

  // R5
  wide_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_vld_o && prec == PREC_WIDE) |-> (a32_o == $past(op_a) && b32_o == $past(op_b)));
endmodule

// File: tb/prec_sched_top_tb.sv
module prec_sched_top_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [1:0]  p;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'd56,      32'd135,        2'd1},
    '{32'd2456,    32'd756,        2'd2},
    '{32'd3562145, 32'd249632166,  2'd3},
    '{32'd255,     32'd255,        2'd1},
    '{32'd255,     32'd256,        2'd2},
    '{32'd32768,   32'd1,          2'd3},
    '{32'd32767,   32'd32767,      2'd2},
    '{32'd1,       32'd32768,      2'd3}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_vld_i = 1'b0;
  logic        op_sel_i = 1'b0;
  logic        pair_vld_o, clk_en_o;
  logic [1:0]  prec_o;
  logic [7:0]  a8_o, b8_o;
  logic [15:0] a16_o, b16_o;
  logic [31:0] a32_o, b32_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prec_sched_top u_dut (
    .clk_i, .rst_ni, .word_i, .word_vld_i, .op_sel_i,
    .pair_vld_o, .prec_o, .a8_o, .b8_o, .a16_o, .b16_o, .a32_o, .b32_o, .clk_en_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected pair outputs for a classified pair
  task automatic chk_pair(input logic [31:0] a, input logic [31:0] b, input logic [1:0] p);
    chk("R2 pair_vld", {31'd0, pair_vld_o}, 32'd1);
    chk(p == 2'd1 ? "R3 prec" : p == 2'd2 ? "R4 prec" : "R5 prec", {30'd0, prec_o}, {30'd0, p});
    chk("R3 a8", {24'd0, a8_o}, p == 2'd1 ? {24'd0, a[7:0]} : 32'd0);
    chk("R3 b8", {24'd0, b8_o}, p == 2'd1 ? {24'd0, b[7:0]} : 32'd0);
    chk("R4 a16", {16'd0, a16_o}, p == 2'd2 ? {16'd0, a[15:0]} : 32'd0);
    chk("R4 b16", {16'd0, b16_o}, p == 2'd2 ? {16'd0, b[15:0]} : 32'd0);
    chk("R5 a32", a32_o, p == 2'd3 ? a : 32'd0);
    chk("R6 b32", b32_o, p == 2'd3 ? b : 32'd0);
  endtask

  // Drive first then second operand; return at the negedge where the pair shows
  task automatic send_pair(input logic [31:0] a, input logic [31:0] b);
    word_i = a; op_sel_i = 1'b0; word_vld_i = 1'b1;
    @(negedge clk_i);
    word_i = b; op_sel_i = 1'b1;
    @(negedge clk_i);
    word_vld_i = 1'b0;
    @(negedge clk_i);
  endtask

  // From cycle 0 of a new code, enable expected at k >= P with k % P == 0
  task automatic chk_rate(input logic [1:0] p);
    int per;
    per = (p == 2'd1) ? 4 : (p == 2'd2) ? 2 : 1;
    for (int k = 0; k < 9; k++) begin
      chk(p == 2'd1 ? "R7/R11 en" : p == 2'd2 ? "R8/R11 en" : "R9/R11 en",
          {31'd0, clk_en_o}, {31'd0, (k >= per) && (k % per == 0)});
      if (k == 1) chk("R2 pulse ends", {31'd0, pair_vld_o}, 32'd0);
      @(negedge clk_i);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 prec", {30'd0, prec_o}, 32'd0);
    chk("R12 pair_vld", {31'd0, pair_vld_o}, 32'd0);
    chk("R12 a32", a32_o, 32'd0);
    chk("R12 a8", {24'd0, a8_o}, 32'd0);
    chk("R12 en", {31'd0, clk_en_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 idle and R1 unstrobed words ignored
    word_i = 32'd77; op_sel_i = 1'b1; word_vld_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R1 no strobe pair_vld", {31'd0, pair_vld_o}, 32'd0);
      chk("R10 idle en", {31'd0, clk_en_o}, 32'd0);
    end
    chk("R1 no strobe prec", {30'd0, prec_o}, 32'd0);

    foreach (VECS[i]) begin
      send_pair(VECS[i].a, VECS[i].b);
      chk_pair(VECS[i].a, VECS[i].b, VECS[i].p);
      chk_rate(VECS[i].p);
    end

    // Same-cycle: new first operand loaded during classification of previous pair
    word_i = 32'd70000; op_sel_i = 1'b0; word_vld_i = 1'b1;
    @(negedge clk_i);
    word_i = 32'd3; op_sel_i = 1'b1;
    @(negedge clk_i);
    word_i = 32'd9; op_sel_i = 1'b0;
    @(negedge clk_i);
    word_vld_i = 1'b0;
    chk_pair(32'd70000, 32'd3, 2'd3);
    word_i = 32'd4; op_sel_i = 1'b1; word_vld_i = 1'b1;
    @(negedge clk_i);
    word_vld_i = 1'b0;
    @(negedge clk_i);
    chk_pair(32'd9, 32'd4, 2'd1);
    chk_rate(2'd1);

    // R12 reset clears the first operand
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R12 prec after reset", {30'd0, prec_o}, 32'd0);
    chk("R12 b8 after reset", {24'd0, b8_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    word_i = 32'd100; op_sel_i = 1'b1; word_vld_i = 1'b1;
    @(negedge clk_i);
    word_vld_i = 1'b0;
    @(negedge clk_i);
    chk_pair(32'd0, 32'd100, 2'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule